// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control core of an 8-bit successive-approximation converter that a host reaches through a memory-mapped read. The host drives chip select and read strobe low together. That single access returns the result held from the previous conversion and also starts a new conversion. To get a fresh value the host issues one read to start the work, waits for the busy flag to return high, and reads again. The second read also starts another conversion, which the host may simply ignore.

The block steps at half the input clock rate. It drives an active-low busy flag for a fixed frame of 20 input clocks. A hold output tells the external track/hold when to freeze the input. After that, the block tests one bit per divided-clock step, most significant bit first. It drives the trial code to an external DAC and reads back a single comparator bit. The comparator, DAC, reference and track/hold are outside the block.

Top module: `sar_sequencer`

## Requirements
- R1: When `csN` and `rdN` are both low at a rising `clk` edge while `busyN` is high, `busyN` is low after that edge.
- R2: `dataOut` shows the result of the previous conversion during the starting access. It does not change while a conversion runs.
- R3: `busyN` stays low for exactly 20 `clk` cycles, which are 10 divided-clock steps. It is high after the 20th edge that follows the start edge.
- R4: The trial code on `dacCode` changes only every second `clk` edge. Counting the start edge as edge 0, it may change only at even-numbered edges.
- R5: `holdOut` rises at the second edge after the start edge, giving two `clk` cycles of acquisition. It stays high until `busyN` returns high. The strobe is taken only at rising `clk` edges, so the sampling edge is fixed.
- R6: During steps 1 to 8 of a conversion, `dacCode` equals the bits already decided plus a single trial bit, tested from bit 7 down to bit 0. At the end of each step, the trial bit is kept if `cmpIn` is 1 (input at or above the DAC level) and cleared otherwise. During acquisition `dacCode` is 0. After the last decision `dacCode` equals the result.
- R7: `dataOut` takes the 8-bit decided code at the edge where `busyN` returns high. With an ideal comparator whose first transition sits at half an LSB, the code is round(input/LSB), capped at 255.
- R8: A strobe seen while `busyN` is low does not restart, lengthen or alter the conversion, and it does not start a new one.
- R9: While synchronous reset `rst` is high, the block clears `dataOut` to 0, drives `busyN` high and `holdOut` low, and returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; the block steps on every second edge |
| rst | input | 1 | Synchronous reset, active high |
| csN | input | 1 | Chip select, active low |
| rdN | input | 1 | Read strobe, active low |
| cmpIn | input | 1 | Comparator: 1 when the held input is at or above the DAC level |
| dacCode | output | 8 | Trial code for the external DAC |
| holdOut | output | 1 | 1 = external track/hold freezes the input |
| dataOut | output | 8 | Result of the last completed conversion |
| busyN | output | 1 | Low while a conversion runs |

## Verification
A wrong step counter shows up within one divided-clock step, either as a trial code that moves on an odd edge or as `holdOut` rising on the wrong edge. It also shows in the length of the busy frame, which is checked to the exact edge. A wrong comparison register shows up at the next trial code, because every trial code is compared with the expected partial result. It also shows in the published result. A start accepted while busy would stretch or shorten the frame, or raise busy again one cycle after the release.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  // Strobes from the sequencer control to the conversion datapath
  typedef struct packed {
    logic clearSar;   // start: clear decided bits and trial mask
    logic loadMask;   // enter bit phase: set trial bit to MSB
    logic decide;     // end of a bit step: keep or drop trial bit
    logic publish;    // end of frame: copy result to output latch
  } seqStrobes_t;
endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        csN,
  input  logic        rdN,
  output seqStrobes_t strb,
  output logic        busyN,
  output logic        holdOut
);
  localparam int FRAME = 2 * (WIDTH + 2);
  localparam int CW    = $clog2(FRAME);
  localparam logic [CW-1:0] ACQ_LAST  = CW'(1);
  localparam logic [CW-1:0] FIRST_DEC = CW'(3);
  localparam logic [CW-1:0] LAST_DEC  = CW'(2 * WIDTH + 1);
  localparam logic [CW-1:0] FRAME_END = CW'(FRAME - 1);

  logic          busy;
  logic          hold;
  logic [CW-1:0] cnt;    // input clocks since the start edge; cnt[0] is the divided-clock phase
  logic          startReq;

  assign startReq = !csN && !rdN;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      hold <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (startReq) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else begin
      cnt <= cnt + CW'(1);
      if (cnt == ACQ_LAST) hold <= 1'b1;
      if (cnt == FRAME_END) begin
        busy <= 1'b0;
        hold <= 1'b0;
        cnt  <= '0;
      end
    end
  end

  always_comb begin
    strb.clearSar = !busy && startReq;
    strb.loadMask = busy && (cnt == ACQ_LAST);
    strb.decide   = busy && cnt[0] && (cnt >= FIRST_DEC) && (cnt <= LAST_DEC);
    strb.publish  = busy && (cnt == FRAME_END);
  end

  assign busyN   = !busy;
  assign holdOut = hold;

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (busyN && startReq) |=> !busyN); // R1
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (!busyN && startReq && cnt != FRAME_END) |=> (cnt == $past(cnt) + CW'(1))); // R8
  AST_HOLD_AFTER_ACQ: assert property (@(posedge clk) disable iff (rst)
    $rose(holdOut) |-> ($past(!busyN, 2) && !busyN)); // R5
  AST_RELEASE_FROM_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(busyN) |-> $past(holdOut)); // R3
  AST_PUBLISH_AT_END: assert property (@(posedge clk) disable iff (rst)
    strb.publish |=> busyN); // R3
endmodule

// File: rtl/sar_seq_dpath.sv
module sar_seq_dpath
  import sar_seq_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  seqStrobes_t      strb,
  input  logic             cmpIn,
  output logic [WIDTH-1:0] dacCode,
  output logic [WIDTH-1:0] dataOut
);
  localparam logic [WIDTH-1:0] MSB_MASK = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] sar;    // decided bits
  logic [WIDTH-1:0] mask;   // single trial bit, zero outside the bit phase

  always_ff @(posedge clk) begin
    if (rst) begin
      sar     <= '0;
      mask    <= '0;
      dataOut <= '0;
    end else begin
      if (strb.clearSar) begin
        sar  <= '0;
        mask <= '0;
      end
      if (strb.loadMask) mask <= MSB_MASK;
      if (strb.decide) begin
        if (cmpIn) sar <= sar | mask;
        mask <= mask >> 1;
      end
      if (strb.publish) dataOut <= sar;
    end
  end

  assign dacCode = sar | mask;

  AST_ONE_TRIAL_BIT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mask)); // R6
  AST_DROP_ON_LOW_CMP: assert property (@(posedge clk) disable iff (rst)
    (strb.decide && !cmpIn) |=> (sar == $past(sar))); // R6
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !strb.publish |=> $stable(dataOut)); // R2
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
  import sar_seq_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             csN,
  input  logic             rdN,
  input  logic             cmpIn,
  output logic [WIDTH-1:0] dacCode,
  output logic             holdOut,
  output logic [WIDTH-1:0] dataOut,
  output logic             busyN
);
  seqStrobes_t strb;

  sar_seq_ctrl #(.WIDTH(WIDTH)) i_ctrl (
    .clk(clk), .rst(rst), .csN(csN), .rdN(rdN),
    .strb(strb), .busyN(busyN), .holdOut(holdOut)
  );

  sar_seq_dpath #(.WIDTH(WIDTH)) i_dpath (
    .clk(clk), .rst(rst), .strb(strb), .cmpIn(cmpIn),
    .dacCode(dacCode), .dataOut(dataOut)
  );
endmodule

// File: tb/test_sar_sequencer.sv
module test_sar_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME      = 20;

  logic       clk = 1'b0;
  logic       rst, csN, rdN, cmpIn;
  logic [7:0] dacCode, dataOut;
  logic       holdOut, busyN;

  int vin;        // analog input in quarter-LSB units
  int heldQ;      // track/hold model output
  int checks = 0;
  int fails  = 0;
  int lastRes = 0;

  sar_sequencer i_sar_sequencer (
    .clk(clk), .rst(rst), .csN(csN), .rdN(rdN), .cmpIn(cmpIn),
    .dacCode(dacCode), .holdOut(holdOut), .dataOut(dataOut), .busyN(busyN)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // track/hold: follows the input while hold is low
  always @(posedge clk) if (!holdOut) heldQ <= vin;
  // comparator with first transition at half an LSB
  assign cmpIn = (heldQ >= 4 * int'(dacCode) - 2);

  function automatic int expCode(int q);
    int c = (q + 2) / 4;
    if (c > 255) c = 255;
    return c;
  endfunction

  function automatic int expDac(int res, int k);
    int b;
    if (k < 2) return 0;
    if (k > 17) return res;
    b = 7 - (k - 2) / 2;
    return (res & ((8'hFF << (b + 1)) & 8'hFF)) | (1 << b);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one full conversion; qLate replaces the input after sampling;
  // injK >= 0 drives a strobe during busy at that step
  task automatic convert(int q, int qLate, int injK);
    int res = expCode(q);
    int prevDac = 0;
    @(negedge clk);
    vin = q; csN = 0; rdN = 0;
    chk("R2 stale data at start", int'(dataOut), lastRes);
    @(negedge clk);
    csN = 1; rdN = 1;
    for (int k = 0; k < FRAME; k++) begin
      chk("R1/R3 busy low", int'(busyN), 0);
      chk("R5 hold timing", int'(holdOut), (k >= 2) ? 1 : 0);
      chk("R6 trial code", int'(dacCode), expDac(res, k));
      if (k % 2 == 1) chk("R4 code steady over step", int'(dacCode), prevDac);
      chk("R2 latch steady", int'(dataOut), lastRes);
      prevDac = int'(dacCode);
      if (k >= 2) vin = qLate;
      if (k == injK) begin csN = 0; rdN = 0; end
      else begin csN = 1; rdN = 1; end
      @(negedge clk);
    end
    csN = 1; rdN = 1;
    chk("R3 busy released", int'(busyN), 1);
    chk("R7 result", int'(dataOut), res);
    @(negedge clk);
    chk("R8 no restart", int'(busyN), 1);
    lastRes = res;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1; csN = 1; rdN = 1; vin = 0;
    repeat (3) @(negedge clk);
    chk("R9 reset busy", int'(busyN), 1);
    chk("R9 reset hold", int'(holdOut), 0);
    chk("R9 reset data", int'(dataOut), 0);
    rst = 0;
    // directed corners: zero, below and at half LSB, top, clipped
    convert(0, 500, -1);
    convert(1, 900, -1);
    convert(2, 0, -1);
    convert(1017, 3, -1);
    convert(1018, 3, 5);
    convert(1100, 0, 19);
    convert(514, 2, 10);
    // reset in the middle of a conversion
    @(negedge clk); vin = 600; csN = 0; rdN = 0;
    @(negedge clk); csN = 1; rdN = 1;
    repeat (7) @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk("R9 mid reset busy", int'(busyN), 1);
    chk("R9 mid reset hold", int'(holdOut), 0);
    chk("R9 mid reset data", int'(dataOut), 0);
    lastRes = 0;
    // random
    for (int n = 0; n < 40; n++) begin
      int q  = int'($urandom_range(1030, 0));
      int ql = int'($urandom_range(1030, 0));
      int ik = ($urandom_range(3, 0) == 0) ? int'($urandom_range(19, 0)) : -1;
      convert(q, ql, ik);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule